// File: doc/BRIEF.md
# Boost Regulator Fault Supervisor

This block governs the enable line of an on-chip boost regulator. Two 1-bit comparator inputs, one for overcurrent and one for overvoltage, are each qualified by a persistence timer. A fault counts only when its input stays high for the full qualification interval of 1.2 ms. When a fault is confirmed, the supervisor switches the regulator off, latches a sticky flag and raises an interrupt.

After a shutdown, restart follows one of two policies. In automatic mode the supervisor retries every 20 ms. In manual mode it waits for software to write a one-shot restart command. In both modes a retry is refused while an enabled fault input is still asserted.

A small parallel register port holds the regulator enable, the protection enables, the recovery policy and the restart command, and gives clear-on-read access to the sticky flags. Both time intervals are derived from a clock-frequency parameter.

Top module: `boost_fault_sup`

## Requirements
- R1: A fault input whose protection enable is 1 must stay high on N consecutive clock edges to be confirmed, where N = (CLK_HZ/1000)*FAULT_US/1000 (1.2 ms by default). A run of N-1 edges or fewer changes no output and no flag.
- R2: On the edge that confirms a fault, the following all happen together: `conv_en` goes low, the matching sticky flag sets, and `fault_irq` goes high.
- R3: The status register at address 0x02 has four fields: bit 0 is the overcurrent flag, bit 1 the overcurrent protection enable, bit 2 the overvoltage flag and bit 3 the overvoltage protection enable. Both enables reset to 1. A read returns the current flags and clears them at that clock edge. Writes change only the enable bits.
- R4: `fault_irq` is the OR over both faults of (flag AND protection enable). It falls once a status read has cleared the flags.
- R5: The control register at address 0x03 has bit 0 as the recovery mode (0 = automatic, 1 = manual) and bit 2 as the regulator enable, which resets to 0. `conv_en` equals the regulator enable AND NOT shut down.
- R6: In automatic mode the supervisor retries exactly R edges after the shutdown edge, where R = (CLK_HZ/1000)*RECOV_US/1000 (20 ms by default). If an enabled fault input is high at the retry, it stays shut down and retries again R edges later.
- R7: In manual mode the supervisor stays shut down until software writes 1 to control bit 1. That command bit clears itself one cycle later, and the restart takes effect on the following edge. If an enabled fault input is high at that edge, the supervisor stays shut down.
- R8: A fault input whose protection enable is 0 is ignored. It cannot set its flag and cannot shut the regulator down.
- R9: After reset, `conv_en` and `fault_irq` are 0, status reads 0x0A and control reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_det | input | 1 | Overcurrent comparator output |
| ov_det | input | 1 | Overvoltage comparator output |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (status read clears the flags) |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational while `bus_rd` is high, else 0 |
| conv_en | output | 1 | Regulator enable |
| fault_irq | output | 1 | Fault interrupt |

## Verification
The properties assume that software does not clear a protection enable in the same cycle a fault of that kind is confirmed. They also assume that a cleared enable is not set again while its flag is still latched, and that the restart command is never written on two consecutive cycles. The directed stimulus keeps within these rules. It issues every register access as a single-cycle strobe at least one idle cycle apart, changes protection enables only while the matching flag is clear, and holds comparator inputs at levels between accesses.

// File: rtl/boost_sup_pkg.sv
package boost_sup_pkg;

    localparam int NUM_FAULTS = 2;
    localparam int FLT_OC     = 0;
    localparam int FLT_OV     = 1;

    localparam logic [7:0] ADDR_STATUS = 8'h02;
    localparam logic [7:0] ADDR_CTRL   = 8'h03;

    typedef enum logic [1:0] {
        ST_DISABLED   = 2'd0,
        ST_RUNNING    = 2'd1,
        ST_FAULT_WAIT = 2'd2,
        ST_SHUTDOWN   = 2'd3
    } sup_state_e;

    typedef struct packed {
        logic [NUM_FAULTS-1:0] flag;
        logic [NUM_FAULTS-1:0] prot_en;
        logic                  manual;
        logic                  mrcv;
        logic                  boost_en;
    } regs_t;

endpackage

// File: rtl/fault_qual.sv
module fault_qual #(
    parameter int unsigned CNT_MAX = 12,
    parameter int unsigned CW      = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic enable,
    input  logic fault_in,
    output logic pending,
    output logic confirm
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        pending = arm & enable & fault_in;
        confirm = pending && (cnt_q == CW'(CNT_MAX - 1));
        cnt_d   = cnt_q;
        if (!pending || confirm) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/sup_regs.sv
module sup_regs
    import boost_sup_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [7:0]            bus_addr,
    input  logic [7:0]            bus_wdata,
    input  logic [NUM_FAULTS-1:0] set_flag,
    output logic [7:0]            bus_rdata,
    output logic [NUM_FAULTS-1:0] flag,
    output logic [NUM_FAULTS-1:0] prot_en,
    output logic                  manual,
    output logic                  mrcv,
    output logic                  boost_en,
    output logic                  irq
);

    regs_t regs_d, regs_q;
    logic  unused_wbits;

    assign unused_wbits = ^bus_wdata[7:4];

    always_comb begin
        regs_d      = regs_q;
        regs_d.mrcv = 1'b0;
        if (bus_wr && bus_addr == ADDR_STATUS) begin
            regs_d.prot_en[FLT_OC] = bus_wdata[1];
            regs_d.prot_en[FLT_OV] = bus_wdata[3];
        end
        if (bus_wr && bus_addr == ADDR_CTRL) begin
            regs_d.manual   = bus_wdata[0];
            regs_d.mrcv     = bus_wdata[1];
            regs_d.boost_en = bus_wdata[2];
        end
        if (bus_rd && bus_addr == ADDR_STATUS) begin
            regs_d.flag = '0;
        end
        regs_d.flag = regs_d.flag | set_flag;
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_rd) begin
            if (bus_addr == ADDR_STATUS) begin
                bus_rdata = {4'b0000, regs_q.prot_en[FLT_OV], regs_q.flag[FLT_OV],
                             regs_q.prot_en[FLT_OC], regs_q.flag[FLT_OC]};
            end else if (bus_addr == ADDR_CTRL) begin
                bus_rdata = {5'b00000, regs_q.boost_en, regs_q.mrcv, regs_q.manual};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q          <= '0;
            regs_q.prot_en  <= '1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign flag     = regs_q.flag;
    assign prot_en  = regs_q.prot_en;
    assign manual   = regs_q.manual;
    assign mrcv     = regs_q.mrcv;
    assign boost_en = regs_q.boost_en;
    assign irq      = |(regs_q.flag & regs_q.prot_en);

endmodule

// File: rtl/sup_fsm.sv
module sup_fsm
    import boost_sup_pkg::*;
#(
    parameter int unsigned RECOV_CYC = 200,
    parameter int unsigned RW        = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  boost_en,
    input  logic                  manual,
    input  logic                  mrcv,
    input  logic [NUM_FAULTS-1:0] pending,
    input  logic [NUM_FAULTS-1:0] confirm,
    input  logic                  raw_fault,
    output sup_state_e            state,
    output logic                  armed,
    output logic                  conv_en
);

    typedef struct packed {
        sup_state_e    state;
        logic [RW-1:0] rcnt;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic tmo;
    logic retry;

    always_comb begin
        fsm_d = fsm_q;
        tmo   = (fsm_q.rcnt == RW'(RECOV_CYC - 1));
        retry = manual ? mrcv : tmo;
        if (!boost_en) begin
            fsm_d.state = ST_DISABLED;
            fsm_d.rcnt  = '0;
        end else begin
            case (fsm_q.state)
                ST_DISABLED: begin
                    fsm_d.state = ST_RUNNING;
                end
                ST_RUNNING, ST_FAULT_WAIT: begin
                    if (|confirm) begin
                        fsm_d.state = ST_SHUTDOWN;
                        fsm_d.rcnt  = '0;
                    end else if (|pending) begin
                        fsm_d.state = ST_FAULT_WAIT;
                    end else begin
                        fsm_d.state = ST_RUNNING;
                    end
                end
                ST_SHUTDOWN: begin
                    if (!manual) begin
                        fsm_d.rcnt = tmo ? '0 : fsm_q.rcnt + 1'b1;
                    end
                    if (retry) begin
                        fsm_d.rcnt = '0;
                        if (!raw_fault) begin
                            fsm_d.state = ST_RUNNING;
                        end
                    end
                end
                default: begin
                    fsm_d.state = ST_DISABLED;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.state <= ST_DISABLED;
            fsm_q.rcnt  <= '0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state   = fsm_q.state;
    assign armed   = (fsm_q.state == ST_RUNNING) || (fsm_q.state == ST_FAULT_WAIT);
    assign conv_en = boost_en && (fsm_q.state != ST_SHUTDOWN);

endmodule

// File: rtl/boost_fault_sup.sv
module boost_fault_sup
    import boost_sup_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 24_576_000,
    parameter int unsigned FAULT_US = 1200,
    parameter int unsigned RECOV_US = 20000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       oc_det,
    input  logic       ov_det,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       conv_en,
    output logic       fault_irq
);

    localparam int unsigned PERSIST_RAW = (CLK_HZ / 1000) * FAULT_US / 1000;
    localparam int unsigned RECOV_RAW   = (CLK_HZ / 1000) * RECOV_US / 1000;
    localparam int unsigned PERSIST_CYC = (PERSIST_RAW < 1) ? 1 : PERSIST_RAW;
    localparam int unsigned RECOV_CYC   = (RECOV_RAW < 1) ? 1 : RECOV_RAW;
    localparam int unsigned PW          = $clog2(PERSIST_CYC + 1);
    localparam int unsigned RW          = $clog2(RECOV_CYC + 1);

    logic [NUM_FAULTS-1:0] fault_in;
    logic [NUM_FAULTS-1:0] pending;
    logic [NUM_FAULTS-1:0] confirm;
    logic [NUM_FAULTS-1:0] flag;
    logic [NUM_FAULTS-1:0] prot_en;
    logic                  manual;
    logic                  mrcv;
    logic                  boost_en;
    logic                  armed;
    logic                  raw_fault;
    sup_state_e            state;

    assign fault_in[FLT_OC] = oc_det;
    assign fault_in[FLT_OV] = ov_det;
    assign raw_fault        = |(prot_en & fault_in);

    for (genvar g = 0; g < NUM_FAULTS; g++) begin : g_qual
        fault_qual #(
            .CNT_MAX (PERSIST_CYC),
            .CW      (PW)
        ) u_qual (
            .clk      (clk),
            .rst_n    (rst_n),
            .arm      (armed),
            .enable   (prot_en[g]),
            .fault_in (fault_in[g]),
            .pending  (pending[g]),
            .confirm  (confirm[g])
        );
    end

    sup_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .set_flag  (confirm),
        .bus_rdata (bus_rdata),
        .flag      (flag),
        .prot_en   (prot_en),
        .manual    (manual),
        .mrcv      (mrcv),
        .boost_en  (boost_en),
        .irq       (fault_irq)
    );

    sup_fsm #(
        .RECOV_CYC (RECOV_CYC),
        .RW        (RW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .boost_en  (boost_en),
        .manual    (manual),
        .mrcv      (mrcv),
        .pending   (pending),
        .confirm   (confirm),
        .raw_fault (raw_fault),
        .state     (state),
        .armed     (armed),
        .conv_en   (conv_en)
    );

endmodule

// File: rtl/boost_sup_checks.sv
module boost_sup_checks
    import boost_sup_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_rd,
    input logic [7:0]            bus_addr,
    input logic                  conv_en,
    input logic                  fault_irq,
    input logic [NUM_FAULTS-1:0] flag,
    input logic [NUM_FAULTS-1:0] prot_en,
    input logic [NUM_FAULTS-1:0] confirm,
    input logic                  mrcv,
    input logic                  raw_fault,
    input sup_state_e            state
);

    p_fault_shutdown_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|confirm) |=> (!conv_en && fault_irq));

    p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_STATUS && !(|confirm)) |=> (flag == '0));

    p_irq_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_irq) |-> $past(|confirm));

    p_retry_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHUTDOWN && raw_fault) |=> (state != ST_RUNNING));

    p_mrcv_selfclear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mrcv |=> !mrcv);

    p_oc_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_en[FLT_OC] |=> !$rose(flag[FLT_OC]));

    p_ov_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_en[FLT_OV] |=> !$rose(flag[FLT_OV]));

endmodule

bind boost_fault_sup boost_sup_checks u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .conv_en   (conv_en),
    .fault_irq (fault_irq),
    .flag      (flag),
    .prot_en   (prot_en),
    .confirm   (confirm),
    .mrcv      (mrcv),
    .raw_fault (raw_fault),
    .state     (state)
);

// File: tb/boost_fault_sup_tb.sv
module boost_fault_sup_tb;

    localparam int CLK_PERIOD = 10;
    localparam int unsigned TB_CLK_HZ = 10_000;
    localparam int N = (TB_CLK_HZ / 1000) * 1200 / 1000;
    localparam int R = (TB_CLK_HZ / 1000) * 20000 / 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       oc_det = 1'b0;
    logic       ov_det = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       conv_en;
    logic       fault_irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    boost_fault_sup #(.CLK_HZ(TB_CLK_HZ)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .oc_det    (oc_det),
        .ov_det    (ov_det),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .conv_en   (conv_en),
        .fault_irq (fault_irq)
    );

    task automatic check_eq(input string req, input string what,
                            input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=0x%02h expected=0x%02h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        step(1);
        bus_wr    = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1;
        d = bus_rdata;
        step(1);
        bus_rd   = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [7:0] v;
        check_eq("R9", "conv_en after reset", {7'd0, conv_en}, 8'd0);
        check_eq("R9", "irq after reset", {7'd0, fault_irq}, 8'd0);
        reg_read(8'h02, v);
        check_eq("R9", "status after reset", v, 8'h0A);
        reg_read(8'h03, v);
        check_eq("R9", "ctrl after reset", v, 8'h00);
    endtask

    task automatic t_enable();
        reg_write(8'h03, 8'h04);
        check_eq("R5", "conv_en after enable", {7'd0, conv_en}, 8'd1);
        step(1);
    endtask

    task automatic t_short_pulse();
        logic [7:0] v;
        oc_det = 1'b1;
        step(N - 1);
        oc_det = 1'b0;
        step(2);
        check_eq("R1", "conv_en after short pulse", {7'd0, conv_en}, 8'd1);
        check_eq("R1", "irq after short pulse", {7'd0, fault_irq}, 8'd0);
        reg_read(8'h02, v);
        check_eq("R1", "status after short pulse", v, 8'h0A);
    endtask

    task automatic t_auto_recovery();
        logic [7:0] v;
        oc_det = 1'b1;
        step(N);
        oc_det = 1'b0;
        check_eq("R2", "conv_en on confirm", {7'd0, conv_en}, 8'd0);
        check_eq("R2", "irq on confirm", {7'd0, fault_irq}, 8'd1);
        step(R - 1);
        check_eq("R6", "conv_en one cycle before retry", {7'd0, conv_en}, 8'd0);
        step(1);
        check_eq("R6", "conv_en at auto retry", {7'd0, conv_en}, 8'd1);
        reg_read(8'h02, v);
        check_eq("R3", "status with oc flag", v, 8'h0B);
        check_eq("R4", "irq after clearing read", {7'd0, fault_irq}, 8'd0);
        reg_read(8'h02, v);
        check_eq("R3", "status after clear-on-read", v, 8'h0A);
    endtask

    task automatic t_auto_retry_blocked();
        logic [7:0] v;
        oc_det = 1'b1;
        step(N);
        check_eq("R2", "conv_en on second confirm", {7'd0, conv_en}, 8'd0);
        step(R);
        check_eq("R6", "conv_en retry with fault held", {7'd0, conv_en}, 8'd0);
        oc_det = 1'b0;
        step(R - 1);
        check_eq("R6", "conv_en before second retry", {7'd0, conv_en}, 8'd0);
        step(1);
        check_eq("R6", "conv_en at second retry", {7'd0, conv_en}, 8'd1);
        reg_read(8'h02, v);
    endtask

    task automatic t_manual_recovery();
        logic [7:0] v;
        reg_write(8'h03, 8'h05);
        step(1);
        ov_det = 1'b1;
        step(N);
        ov_det = 1'b0;
        check_eq("R2", "conv_en on ov confirm", {7'd0, conv_en}, 8'd0);
        step(R + 10);
        check_eq("R7", "manual mode holds shutdown", {7'd0, conv_en}, 8'd0);
        reg_read(8'h02, v);
        check_eq("R3", "status with ov flag", v, 8'h0E);
        reg_write(8'h03, 8'h07);
        check_eq("R7", "conv_en one cycle after restart write", {7'd0, conv_en}, 8'd0);
        step(1);
        check_eq("R7", "conv_en after restart", {7'd0, conv_en}, 8'd1);
        reg_read(8'h03, v);
        check_eq("R7", "restart bit self-cleared", v, 8'h05);
    endtask

    task automatic t_manual_blocked();
        logic [7:0] v;
        ov_det = 1'b1;
        step(N);
        reg_write(8'h03, 8'h07);
        step(2);
        check_eq("R7", "restart refused while fault held", {7'd0, conv_en}, 8'd0);
        ov_det = 1'b0;
        reg_write(8'h03, 8'h07);
        step(1);
        check_eq("R7", "restart after fault gone", {7'd0, conv_en}, 8'd1);
        reg_read(8'h02, v);
    endtask

    task automatic t_ignored();
        logic [7:0] v;
        reg_write(8'h02, 8'h08);
        oc_det = 1'b1;
        step(2 * N);
        check_eq("R8", "conv_en with oc disabled", {7'd0, conv_en}, 8'd1);
        check_eq("R8", "irq with oc disabled", {7'd0, fault_irq}, 8'd0);
        reg_read(8'h02, v);
        check_eq("R8", "status with oc disabled", v, 8'h08);
        oc_det = 1'b0;
        reg_write(8'h02, 8'h0A);
        reg_write(8'h03, 8'h00);
        check_eq("R5", "conv_en after disable", {7'd0, conv_en}, 8'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        t_reset_state();
        t_enable();
        t_short_pulse();
        t_auto_recovery();
        t_auto_retry_blocked();
        t_manual_recovery();
        t_manual_blocked();
        t_ignored();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule